// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block drives a small set of programmable clock outputs from one fast system clock. The input sources are single-cycle enable ticks on that clock. Each output picks one source through its own configuration word. It then divides the selected tick stream by a prescaler and produces a duty-shaped output level, which is high for the first half of each output period.

The prescaler works in one of two ways, chosen at build time. In linear mode the divisor is the field value plus one. In power-of-two mode it is two raised to the field value, and the all-ones code is reserved. An optional master-clock bit widens the source choice to a fifth tick, but only when the base select field is zero.

Outputs are switched on and off through a set address and a clear address. A shared status word reports which outputs are enabled and which are running. Configuration can be changed only while an output is gated off. A synchronous write port with one-cycle read-back gives access to everything.

Top module: `pclk_gen`

## Requirements
- R1: A synchronous active-high reset clears every configuration word to source 0 and prescaler 0, disables every output, and drives all outputs, ready flags and read data to zero.
- R2: In linear mode, with prescaler field P and divisor D = P+1, the output counts selected source ticks from zero at enable. It is high for the first floor(D/2) ticks of each D-tick period and low for the rest. When D = 1 the output equals the selected tick in the same cycle.
- R3: In power-of-two mode the divisor is D = 2^P, and the output follows the same counting and high-half shape as in R2.
- R4: In power-of-two mode, a configuration write whose prescaler field (bits 6:4) is all ones is ignored as a whole, and the previous word stays.
- R5: Base select codes 0 to 3 in bits 1:0 choose src_tick[0] to src_tick[3].
- R6: With the master-clock option, bit 2 set together with base code 0 selects src_tick[4]. With a non-zero base code, the base code wins, and bit 2 is still stored and read back.
- R7: Without the master-clock option, a configuration write with bit 2 set is rejected as a whole, and bit 2 always reads back as 0.
- R8: A configuration write to an output that is enabled is ignored.
- R9: A write to address 0xC sets the enable bits given by the ones in wdata, and a write to 0xD clears them. A disabled output is held low, and its counter restarts from zero at the next enable.
- R10: An output's ready flag rises in the cycle after the first selected tick seen while it is enabled. It falls in the cycle after the output becomes disabled.
- R11: Configuration word i sits at address i, and the status word sits at 0xE. The status word holds enables at bits [N-1:0] and the ready flag of output i at bit i+8. Read data appears on the clock edge after the address is presented, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | NSRC (5, or 4 without master option) | Source enable ticks, index 4 is the master clock |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (4) | Register address for write and read |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Registered read data |
| pck_out | output | NUM_OUT (3) | Programmable clock output levels |
| pck_ready | output | NUM_OUT (3) | Per-output ready flags |

## Verification
Each output level depends on a counter updated at the previous edge and on the tick in the current cycle. The bench therefore drives ticks at the falling edge and compares the levels 1 ns later, before the next rising edge. Enable, configuration and ready changes are due one rising edge after their write or tick. The bench's model applies them at that edge, with the counter step taken from the pre-edge state. Read data is due exactly one edge after the address. The expected word is computed before that edge and compared just after it, and one directed case confirms that the old value is still present before the edge.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int CFG_SEL_LSB  = 0;
  localparam int CFG_MCK_BIT  = 2;
  localparam int CFG_PRES_LSB = 4;
  localparam int STAT_RDY_LSB = 8;
  localparam int ADDR_EN_SET  = 12;
  localparam int ADDR_EN_CLR  = 13;
  localparam int ADDR_STATUS  = 14;
  localparam int MCK_INDEX    = 4;

  // Divisor for a prescaler code in either mode.
  function automatic logic [31:0] pres_divisor(input logic [7:0] code, input logic pow2);
    if (pow2) return 32'd1 << code;
    return {24'd0, code} + 32'd1;
  endfunction

  // Effective source index from base select and master bit.
  function automatic logic [2:0] eff_source(input logic [1:0] sel, input logic mck,
                                            input logic ext);
    if (ext && mck && sel == 2'd0) return 3'(MCK_INDEX);
    return {1'b0, sel};
  endfunction

  // Whether a configuration word is a legal setting for this variant.
  function automatic logic cfg_legal(input logic [7:0] pres, input logic [7:0] pres_max,
                                     input logic mck, input logic pow2, input logic ext);
    if (pow2 && pres == pres_max) return 1'b0;
    if (!ext && mck) return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
  import pclk_pkg::*;
#(
  parameter int NUM_OUT = 3,
  parameter int PRES_W  = 3,
  parameter int POW2    = 0,
  parameter int EXT_MCK = 1,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_OUT-1:0]             rdy,
  output logic [NUM_OUT-1:0]             en_q,
  output logic [NUM_OUT-1:0][1:0]        sel_q,
  output logic [NUM_OUT-1:0]             mck_q,
  output logic [NUM_OUT-1:0][PRES_W-1:0] pres_q,
  output logic [NUM_OUT-1:0]             cfg_acc,
  output logic [DATA_W-1:0]              rdata
);
  localparam logic [7:0] PRES_MAX8 = 8'((2 ** PRES_W) - 1);

  logic [NUM_OUT-1:0][DATA_W-1:0] cfg_word;
  logic [DATA_W-1:0]              stat_word;
  logic [DATA_W-1:0]              rd_next;
  logic                           en_set, en_clr;

  assign en_set = wr_en && (addr == ADDR_W'(ADDR_EN_SET));
  assign en_clr = wr_en && (addr == ADDR_W'(ADDR_EN_CLR));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cfg
    logic       hit;
    logic [7:0] wpres;
    assign hit        = wr_en && (addr == ADDR_W'(i));
    assign wpres      = 8'(wdata[CFG_PRES_LSB +: PRES_W]);
    assign cfg_acc[i] = hit && !en_q[i] &&
                        cfg_legal(wpres, PRES_MAX8, wdata[CFG_MCK_BIT], POW2 != 0, EXT_MCK != 0);

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[i]  <= '0;
        mck_q[i]  <= 1'b0;
        pres_q[i] <= '0;
      end else if (cfg_acc[i]) begin
        sel_q[i]  <= wdata[CFG_SEL_LSB +: 2];
        mck_q[i]  <= (EXT_MCK != 0) ? wdata[CFG_MCK_BIT] : 1'b0;
        pres_q[i] <= wdata[CFG_PRES_LSB +: PRES_W];
      end
    end

    assign cfg_word[i] = DATA_W'({pres_q[i], 1'b0, mck_q[i], sel_q[i]});
  end

  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (en_set) en_q <= en_q | wdata[NUM_OUT-1:0];
    else if (en_clr) en_q <= en_q & ~wdata[NUM_OUT-1:0];
  end

  always_comb begin
    stat_word = '0;
    stat_word[NUM_OUT-1:0] = en_q;
    stat_word[STAT_RDY_LSB +: NUM_OUT] = rdy;
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(ADDR_STATUS)) rd_next = stat_word;
    for (int i = 0; i < NUM_OUT; i++)
      if (addr == ADDR_W'(i)) rd_next = cfg_word[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/pclk_div.sv
module pclk_div
  import pclk_pkg::*;
#(
  parameter int PRES_W = 3,
  parameter int POW2   = 0,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PRES_W-1:0] pres,
  input  logic              tick,
  output logic              level,
  output logic              rdy,
  output logic              wrap,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  div
);
  logic [31:0] div_full;

  assign div_full = pres_divisor(8'(pres), POW2 != 0);
  assign div      = CNT_W'(div_full);
  assign wrap     = en && tick && (cnt == div - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (tick)   cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) rdy <= 1'b0;
    else if (tick)  rdy <= 1'b1;
  end

  assign level = en && ((div == CNT_W'(1)) ? tick : (cnt < (div >> 1)));
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
  import pclk_pkg::*;
#(
  parameter int NUM_OUT = 3,
  parameter int PRES_W  = 3,
  parameter int POW2    = 0,
  parameter int EXT_MCK = 1,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [(EXT_MCK != 0 ? 5 : 4)-1:0] src_tick,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic [NUM_OUT-1:0]     pck_out,
  output logic [NUM_OUT-1:0]     pck_ready
);
  localparam int NSRC  = (EXT_MCK != 0) ? 5 : 4;
  localparam int MAXD  = (POW2 != 0) ? 2 ** ((2 ** PRES_W) - 2) : 2 ** PRES_W;
  localparam int CNT_W = $clog2(MAXD + 1);

  logic [NUM_OUT-1:0]             en_q;
  logic [NUM_OUT-1:0][1:0]        sel_q;
  logic [NUM_OUT-1:0]             mck_q;
  logic [NUM_OUT-1:0][PRES_W-1:0] pres_q;
  logic [NUM_OUT-1:0]             cfg_acc;
  logic [NUM_OUT-1:0]             sel_tick;
  logic [NUM_OUT-1:0]             wrap_v;
  logic [NUM_OUT-1:0][CNT_W-1:0]  cnt_v;
  logic [NUM_OUT-1:0][CNT_W-1:0]  div_v;

  pclk_regs #(
    .NUM_OUT(NUM_OUT), .PRES_W(PRES_W), .POW2(POW2), .EXT_MCK(EXT_MCK),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdy(pck_ready), .en_q(en_q), .sel_q(sel_q), .mck_q(mck_q),
    .pres_q(pres_q), .cfg_acc(cfg_acc), .rdata(rdata)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic [2:0] idx;
    logic       t;
    assign idx = eff_source(sel_q[i], mck_q[i], EXT_MCK != 0);
    always_comb begin
      t = 1'b0;
      for (int s = 0; s < NSRC; s++)
        if (idx == 3'(s)) t = src_tick[s];
    end
    assign sel_tick[i] = t;

    pclk_div #(.PRES_W(PRES_W), .POW2(POW2), .CNT_W(CNT_W)) u_div (
      .clk(clk), .rst(rst), .en(en_q[i]), .pres(pres_q[i]), .tick(sel_tick[i]),
      .level(pck_out[i]), .rdy(pck_ready[i]), .wrap(wrap_v[i]),
      .cnt(cnt_v[i]), .div(div_v[i])
    );
  end
endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk #(
  parameter int NUM_OUT = 3,
  parameter int PRES_W  = 3,
  parameter int POW2    = 0,
  parameter int EXT_MCK = 1,
  parameter int CNT_W   = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NUM_OUT-1:0]             en_q,
  input logic [NUM_OUT-1:0]             sel_tick,
  input logic [NUM_OUT-1:0]             pck_out,
  input logic [NUM_OUT-1:0]             pck_ready,
  input logic [NUM_OUT-1:0][1:0]        sel_q,
  input logic [NUM_OUT-1:0]             mck_q,
  input logic [NUM_OUT-1:0][PRES_W-1:0] pres_q,
  input logic [NUM_OUT-1:0][CNT_W-1:0]  cnt_v,
  input logic [NUM_OUT-1:0][CNT_W-1:0]  div_v
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (en_q == '0 && pck_ready == '0));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
    p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (rst)
      en_q[i] |-> (cnt_v[i] < div_v[i]));
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
      en_q[i] |=> ($stable(pres_q[i]) && $stable(sel_q[i]) && $stable(mck_q[i])));
    p_gated_low_r9: assert property (@(posedge clk) disable iff (rst)
      !en_q[i] |-> !pck_out[i]);
    p_restart_zero_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(en_q[i]) |-> (cnt_v[i] == '0));
    p_ready_drop_r10: assert property (@(posedge clk) disable iff (rst)
      !en_q[i] |=> !pck_ready[i]);
    p_ready_rise_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(pck_ready[i]) |-> ($past(sel_tick[i]) && $past(en_q[i])));
    if (POW2 != 0) begin : g_p2
      p_no_top_code_r4: assert property (@(posedge clk) disable iff (rst)
        pres_q[i] != {PRES_W{1'b1}});
    end
    if (EXT_MCK == 0) begin : g_nomck
      p_no_master_bit_r7: assert property (@(posedge clk) disable iff (rst) !mck_q[i]);
    end
  end
endmodule

bind pclk_gen pclk_gen_chk #(
  .NUM_OUT(NUM_OUT), .PRES_W(PRES_W), .POW2(POW2), .EXT_MCK(EXT_MCK), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/pclk_gen_bench.sv
`timescale 1ns/1ps
module pclk_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  src = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rd0, rd1;
  logic [2:0]  out0, out1, rdy0, rdy1;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int m_en [2][3], m_cnt [2][3], m_rdy [2][3];
  int m_sel [2][3], m_mck [2][3], m_pres [2][3];

  always #5 clk = ~clk;

  pclk_gen u_pclk_gen (
    .clk(clk), .rst(rst), .src_tick(src), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rd0), .pck_out(out0), .pck_ready(rdy0));

  pclk_gen #(.POW2(1), .EXT_MCK(0)) u_pclk_gen_p2 (
    .clk(clk), .rst(rst), .src_tick(src[3:0]), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rd1), .pck_out(out1), .pck_ready(rdy1));

  function automatic int f_div(int d, int p);
    return (d == 0) ? p + 1 : (1 << p);
  endfunction
  function automatic int f_src(int d, int sel, int mck);
    return (d == 0 && mck != 0 && sel == 0) ? 4 : sel;
  endfunction
  function automatic int f_cfg(int d, int i);
    return (m_pres[d][i] << 4) | (m_mck[d][i] << 2) | m_sel[d][i];
  endfunction
  function automatic int f_stat(int d);
    int v = 0;
    for (int i = 0; i < 3; i++) v |= (m_en[d][i] << i) | (m_rdy[d][i] << (8 + i));
    return v;
  endfunction
  function automatic int f_tick(int d, int i);
    return (src >> f_src(d, m_sel[d][i], m_mck[d][i])) & 1;
  endfunction
  function automatic int f_level(int d, int i);
    int dv = f_div(d, m_pres[d][i]);
    if (m_en[d][i] == 0) return 0;
    if (dv == 1) return f_tick(d, i);
    return (m_cnt[d][i] < dv / 2) ? 1 : 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 3; i++) begin
        int dv = f_div(d, m_pres[d][i]);
        if (m_en[d][i] == 0) begin m_cnt[d][i] = 0; m_rdy[d][i] = 0; end
        else if (f_tick(d, i) != 0) begin
          m_cnt[d][i] = (m_cnt[d][i] == dv - 1) ? 0 : m_cnt[d][i] + 1;
          m_rdy[d][i] = 1;
        end
      end
      if (wr_en) begin
        int p = (wdata >> 4) & 7, mk = (wdata >> 2) & 1;
        if (addr < 3) begin
          bit ok = (m_en[d][addr] == 0) && !(d == 1 && p == 7) && !(d == 1 && mk == 1);
          if (ok) begin
            m_sel[d][addr] = wdata & 3; m_mck[d][addr] = mk; m_pres[d][addr] = p;
          end
        end else if (addr == 12) begin
          for (int i = 0; i < 3; i++) if (wdata[i]) m_en[d][i] = 1;
        end else if (addr == 13) begin
          for (int i = 0; i < 3; i++) if (wdata[i]) m_en[d][i] = 0;
        end
      end
    end
  endtask

  // Entered at a falling edge with inputs already driven.
  task automatic cycle(string tag);
    #1;
    for (int i = 0; i < 3; i++) begin
      chk(out0[i] == f_level(0, i), {"R2 ", tag}, out0[i], f_level(0, i));
      chk(out1[i] == f_level(1, i), {"R3 ", tag}, out1[i], f_level(1, i));
      chk(rdy0[i] == m_rdy[0][i], {"R10 ", tag}, rdy0[i], m_rdy[0][i]);
      chk(rdy1[i] == m_rdy[1][i], {"R10 ", tag}, rdy1[i], m_rdy[1][i]);
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic wr(int a, int v, string tag);
    wr_en = 1'b1; addr = 4'(a); wdata = 16'(v); src = '0;
    cycle(tag);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(int a, string tag);
    int e0, e1;
    wr_en = 1'b0; addr = 4'(a); src = '0;
    e0 = (a < 3) ? f_cfg(0, a) : (a == 14 ? f_stat(0) : 0);
    e1 = (a < 3) ? f_cfg(1, a) : (a == 14 ? f_stat(1) : 0);
    cycle(tag);
    chk(rd0 == 16'(e0), {"R11 ", tag}, rd0, e0);
    chk(rd1 == 16'(e1), {"R11 ", tag}, rd1, e1);
  endtask

  task automatic run(int n, int dens, string tag);
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 5; b++) src[b] = (($urandom % 100) < dens);
      cycle(tag);
    end
    src = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 3; i++) begin
        m_en[d][i] = 0; m_cnt[d][i] = 0; m_rdy[d][i] = 0;
        m_sel[d][i] = 0; m_mck[d][i] = 0; m_pres[d][i] = 0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd0 == 0 && out0 == 0 && rdy0 == 0, "R1 reset outputs", {rd0, out0, rdy0}, 0);
    rst = 1'b0;
    for (int a = 0; a < 3; a++) rd_chk(a, "R1");
    rd_chk(14, "R1");
    // R5: every base code on output 0, divisor 2
    for (int c = 0; c < 4; c++) begin
      wr(0, c | (1 << 4), "R5");
      wr(12, 1, "R9");
      run(30, 40, "R5");
      wr(13, 1, "R9");
      run(2, 40, "R10");
    end
    // R6 and R7: master bit, pass-through divisor
    wr(1, 4, "R6");
    rd_chk(1, "R7");
    wr(12, 2, "R9");
    run(20, 50, "R6");
    wr(13, 2, "R9");
    wr(1, 2 | 4 | (2 << 4), "R6");
    rd_chk(1, "R6");
    wr(12, 2, "R9");
    run(30, 50, "R6");
    wr(13, 2, "R9");
    // R4: all-ones prescaler code
    wr(2, 1 | (7 << 4), "R4");
    rd_chk(2, "R4");
    wr(12, 4, "R9");
    run(40, 60, "R4");
    // R8: write while enabled
    wr(2, 3 | (2 << 4), "R8");
    rd_chk(2, "R8");
    run(10, 60, "R8");
    rd_chk(14, "R10");
    wr(13, 4, "R10");
    rd_chk(14, "R10");
    rd_chk(14, "R10");
    // R11: latency, old data still present before the edge
    rd_chk(0, "R11");
    addr = 4'd14; #1;
    chk(rd0 == 16'(f_cfg(0, 0)), "R11 hold before edge", rd0, f_cfg(0, 0));
    @(negedge clk);
    rd_chk(9, "R11 unmapped");
    // Random mix
    for (int it = 0; it < 40; it++) begin
      wr(13, 7, "R9");
      for (int i = 0; i < 3; i++) wr(i, $urandom & 16'h0077, "R4 R7");
      for (int i = 0; i < 3; i++) rd_chk(i, "R11");
      wr(12, $urandom & 7, "R9");
      run(60, 20 + ($urandom % 70), "R2 R3");
      rd_chk(14, "R10");
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule